// File: doc/BRIEF.md
# Instruction Cache Control and Maintenance Unit

This block is the software-visible control point of an instruction cache. A small word-addressed register bus (byte address, write strobe, write data and a combinational read-data return) reaches six registers: control, status, interrupt enable, a write-only flag-clear register, and two read-only event counters. The control register holds the global cache enable, the associativity select, the enables and clear strobes of the counters, and a request bit that launches a full invalidation of the tag array.

A full invalidation walks every tag line from index 0 upward, one line per clock. Each step drives a strobe and a line index on the tag-clear port. A busy flag is raised for the whole walk, and a done flag is raised when the walk ends. An external error pulse raises an error flag. Either sticky flag can raise the interrupt line when its enable bit is set. Hit and miss pulses from the lookup logic feed two saturating counters of different widths.

Top module: `cache_maint_ctrl`

## Requirements
- R1: After reset the control word (offset 0x00) reads 0x0000_0004, and status (0x04), interrupt enable (0x08), hit count (0x10) and miss count (0x14) read 0. Flag clear (0x0C) and any unmapped offset read 0.
- R2: Control bit 0 is the cache enable and bit 2 the associativity select (0 one-way, 1 multi-way). Bits 16 and 17 enable the hit and miss counters. Bits 18 and 19 are clear strobes that always read back 0.
- R3: Writing 1 to control bit 1 while no walk runs sets a request bit that starts an invalidation. The bit reads 1 until the cycle after busy rises, and then returns to 0. A write with bit 1 at 0 starts nothing. A request written while busy is 1 is dropped.
- R4: Control bit 2 takes a written value only while the stored enable bit is 0. While the enable is 1, writes leave bit 2 unchanged.
- R5: During an invalidation, status bit 0 (busy) is 1 and the tag-clear strobe is high for exactly LINES consecutive cycles, with the line index going 0, 1, ..., LINES-1.
- R6: In the cycle after the last line index, busy is 0 and status bit 1 (done) is 1.
- R7: A one-cycle pulse on the error input sets status bit 2 (error), and the bit stays set.
- R8: Writing 1 to flag-clear bit 1 clears done, and writing 1 to flag-clear bit 2 clears error. Writes to the status offset change nothing.
- R9: The interrupt output is high exactly when (done AND interrupt-enable bit 1) OR (error AND interrupt-enable bit 2).
- R10: The 32-bit hit counter (0x10) and the 16-bit miss counter (0x14, low half) count one per cycle in which their input pulse is high, but only while their enable bit is 1.
- R11: A clear strobe (bit 18 for hit, bit 19 for miss) zeroes its counter, and a clear wins over an increment in the same cycle.
- R12: A counter at its all-ones value holds that value on further increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| hit_pulse | input | 1 | One count per cycle for a cache hit |
| miss_pulse | input | 1 | One count per cycle for a cache miss |
| err_pulse | input | 1 | Error event that sets the error flag |
| tag_clr_vld | output | 1 | Tag line clear strobe |
| tag_clr_idx | output | IDX_W | Index of the line being cleared |
| irq | output | 1 | Interrupt request |

## Verification
The hardest states to reach from the ports are the collisions. One is a clear strobe that lands in the same cycle as a counter increment. The bench raises both pulse inputs in the exact cycle of the control write, so the hit counter must end at zero while the miss counter goes up by one. Another is a request written while a walk is running: the bench writes it after busy has been seen, and counts that no second run of tag strobes follows. Counter saturation is reached by holding the miss pulse high for slightly more than 65,536 cycles.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

    localparam int DATA_W = 32;

    // byte offsets of the register words
    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_STAT  = 8'h04;
    localparam logic [7:0] OFS_IEN   = 8'h08;
    localparam logic [7:0] OFS_FCLR  = 8'h0C;
    localparam logic [7:0] OFS_HITS  = 8'h10;
    localparam logic [7:0] OFS_MISS  = 8'h14;

    // control word bit positions
    localparam int B_EN      = 0;
    localparam int B_INV     = 1;
    localparam int B_WAY     = 2;
    localparam int B_HIT_EN  = 16;
    localparam int B_MISS_EN = 17;
    localparam int B_HIT_CLR = 18;
    localparam int B_MISS_CLR= 19;

    // flag / enable bit positions shared by status, clear and enable words
    localparam int B_DONE = 1;
    localparam int B_ERR  = 2;

    typedef struct packed {
        logic miss_en;
        logic hit_en;
        logic way;
        logic inv;
        logic en;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{miss_en: 1'b0, hit_en: 1'b0, way: 1'b1,
                                   inv: 1'b0, en: 1'b0};

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[B_EN]      = c.en;
        w[B_INV]     = c.inv;
        w[B_WAY]     = c.way;
        w[B_HIT_EN]  = c.hit_en;
        w[B_MISS_EN] = c.miss_en;
        return w;
    endfunction

endpackage

// File: rtl/cmc_inval_walk.sv
module cmc_inval_walk #(
    parameter int LINES = 64,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             busy,
    output logic             finish,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(LINES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                idx  <= '0;
            end
        end else if (idx == LAST) begin
            busy <= 1'b0;
        end else begin
            idx <= idx + 1'b1;
        end
    end

    assign finish = busy && (idx == LAST);

endmodule

// File: rtl/cmc_sat_ctr.sv
module cmc_sat_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc && count != TOP) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/cache_maint_ctrl.sv
module cache_maint_ctrl
    import cmc_pkg::*;
#(
    parameter int LINES  = 64,
    parameter int ADDR_W = 5,
    parameter int HIT_W  = 32,
    parameter int MISS_W = 16,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              hit_pulse,
    input  logic              miss_pulse,
    input  logic              err_pulse,
    output logic              tag_clr_vld,
    output logic [IDX_W-1:0]  tag_clr_idx,
    output logic              irq
);
    localparam int WA_W = ADDR_W - 2;

    logic [WA_W-1:0] word;
    logic sel_ctrl, sel_stat, sel_ien, sel_fclr, sel_hits, sel_miss;
    logic wr_ctrl, wr_ien, wr_fclr;

    ctrl_t ctrl_q;
    logic  busy, finish;
    logic  done_q, err_q;
    logic  ie_done_q, ie_err_q;
    logic [HIT_W-1:0]  hit_cnt;
    logic [MISS_W-1:0] miss_cnt;
    logic  unused_bits;

    assign word     = bus_addr[ADDR_W-1:2];
    assign sel_ctrl = (word == OFS_CTRL[ADDR_W-1:2]);
    assign sel_stat = (word == OFS_STAT[ADDR_W-1:2]);
    assign sel_ien  = (word == OFS_IEN[ADDR_W-1:2]);
    assign sel_fclr = (word == OFS_FCLR[ADDR_W-1:2]);
    assign sel_hits = (word == OFS_HITS[ADDR_W-1:2]);
    assign sel_miss = (word == OFS_MISS[ADDR_W-1:2]);

    assign wr_ctrl = bus_wr && sel_ctrl;
    assign wr_ien  = bus_wr && sel_ien;
    assign wr_fclr = bus_wr && sel_fclr;

    assign unused_bits = ^{bus_addr[1:0], sel_stat, sel_fclr, bus_wdata[31:20],
                           bus_wdata[15:3]};

    // control word
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.en      <= bus_wdata[B_EN];
                ctrl_q.hit_en  <= bus_wdata[B_HIT_EN];
                ctrl_q.miss_en <= bus_wdata[B_MISS_EN];
                if (!ctrl_q.en) begin
                    ctrl_q.way <= bus_wdata[B_WAY];
                end
            end
            if (wr_ctrl && bus_wdata[B_INV] && !busy) begin
                ctrl_q.inv <= 1'b1;
            end else if (busy) begin
                ctrl_q.inv <= 1'b0;
            end
        end
    end

    // interrupt enables
    always_ff @(posedge clk) begin
        if (rst) begin
            ie_done_q <= 1'b0;
            ie_err_q  <= 1'b0;
        end else if (wr_ien) begin
            ie_done_q <= bus_wdata[B_DONE];
            ie_err_q  <= bus_wdata[B_ERR];
        end
    end

    // sticky flags: a set in the same cycle wins over a clear
    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (finish)
                done_q <= 1'b1;
            else if (wr_fclr && bus_wdata[B_DONE])
                done_q <= 1'b0;
            if (err_pulse)
                err_q <= 1'b1;
            else if (wr_fclr && bus_wdata[B_ERR])
                err_q <= 1'b0;
        end
    end

    assign irq = (done_q && ie_done_q) || (err_q && ie_err_q);

    cmc_inval_walk #(.LINES(LINES)) u_walk (
        .clk    (clk),
        .rst    (rst),
        .start  (ctrl_q.inv),
        .busy   (busy),
        .finish (finish),
        .idx    (tag_clr_idx)
    );

    assign tag_clr_vld = busy;

    cmc_sat_ctr #(.W(HIT_W)) u_hits (
        .clk   (clk),
        .rst   (rst),
        .clr   (wr_ctrl && bus_wdata[B_HIT_CLR]),
        .inc   (hit_pulse && ctrl_q.hit_en),
        .count (hit_cnt)
    );

    cmc_sat_ctr #(.W(MISS_W)) u_miss (
        .clk   (clk),
        .rst   (rst),
        .clr   (wr_ctrl && bus_wdata[B_MISS_CLR]),
        .inc   (miss_pulse && ctrl_q.miss_en),
        .count (miss_cnt)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl) begin
            bus_rdata = pack_ctrl(ctrl_q);
        end else if (sel_stat) begin
            bus_rdata[0]      = busy;
            bus_rdata[B_DONE] = done_q;
            bus_rdata[B_ERR]  = err_q;
        end else if (sel_ien) begin
            bus_rdata[B_DONE] = ie_done_q;
            bus_rdata[B_ERR]  = ie_err_q;
        end else if (sel_hits) begin
            bus_rdata[HIT_W-1:0] = hit_cnt;
        end else if (sel_miss) begin
            bus_rdata[MISS_W-1:0] = miss_cnt;
        end
    end

endmodule

// File: rtl/cache_maint_ctrl_chk.sv
module cache_maint_ctrl_chk #(
    parameter int LINES  = 64,
    parameter int ADDR_W = 5,
    parameter int MISS_W = 16,
    parameter int IDX_W  = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic              en_q,
    input logic              way_q,
    input logic              inv_q,
    input logic              busy,
    input logic              done_q,
    input logic              err_q,
    input logic              irq,
    input logic              tag_clr_vld,
    input logic [IDX_W-1:0]  tag_clr_idx,
    input logic [MISS_W-1:0] miss_cnt
);
    localparam logic [IDX_W-1:0]  LAST = IDX_W'(LINES - 1);
    localparam logic [MISS_W-1:0] MTOP = '1;

    // R4: associativity select frozen while enabled
    a_r4_way_locked: assert property (@(posedge clk) disable iff (rst)
        en_q |=> (way_q == $past(way_q)));

    // R3: request bit drops once the walk is running
    a_r3_req_drops: assert property (@(posedge clk) disable iff (rst)
        busy |=> !inv_q);

    // R5: line index advances by one per strobe
    a_r5_index_steps: assert property (@(posedge clk) disable iff (rst)
        (tag_clr_vld && tag_clr_idx != LAST) |=>
            (tag_clr_vld && tag_clr_idx == $past(tag_clr_idx) + 1'b1));

    // R5: a walk starts at index 0
    a_r5_index_start: assert property (@(posedge clk) disable iff (rst)
        $rose(tag_clr_vld) |-> (tag_clr_idx == '0));

    // R6: done follows the last line
    a_r6_done_after_last: assert property (@(posedge clk) disable iff (rst)
        (tag_clr_vld && tag_clr_idx == LAST) |=> (!busy && done_q));

    // R9: quiet interrupt without a flag
    a_r9_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        (!done_q && !err_q) |-> !irq);

    // R11: clear strobe zeroes the miss counter
    a_r11_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr[ADDR_W-1:2] == '0 && bus_wdata[19]) |=> (miss_cnt == '0));

    // R12: no wrap from all-ones
    a_r12_saturate: assert property (@(posedge clk) disable iff (rst)
        (miss_cnt == MTOP) |=> (miss_cnt == MTOP || miss_cnt == '0));

endmodule

bind cache_maint_ctrl cache_maint_ctrl_chk #(
    .LINES(LINES), .ADDR_W(ADDR_W), .MISS_W(MISS_W), .IDX_W(IDX_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .en_q       (ctrl_q.en),
    .way_q      (ctrl_q.way),
    .inv_q      (ctrl_q.inv),
    .busy       (busy),
    .done_q     (done_q),
    .err_q      (err_q),
    .irq        (irq),
    .tag_clr_vld(tag_clr_vld),
    .tag_clr_idx(tag_clr_idx),
    .miss_cnt   (miss_cnt)
);

// File: tb/test_cache_maint_ctrl.sv
module test_cache_maint_ctrl;
    localparam int LINES  = 8;
    localparam int ADDR_W = 5;
    localparam int IDX_W  = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              hit_pulse = 1'b0;
    logic              miss_pulse = 1'b0;
    logic              err_pulse = 1'b0;
    logic              tag_clr_vld;
    logic [IDX_W-1:0]  tag_clr_idx;
    logic              irq;

    always #2.5 clk = ~clk;

    cache_maint_ctrl #(.LINES(LINES), .ADDR_W(ADDR_W)) i_cache_maint_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hit_pulse(hit_pulse),
        .miss_pulse(miss_pulse), .err_pulse(err_pulse), .tag_clr_vld(tag_clr_vld),
        .tag_clr_idx(tag_clr_idx), .irq(irq)
    );

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int total = 0;
    int bad   = 0;
    int strobes = 0;
    logic rd_stb = 1'b0;
    logic finished = 1'b0;

    // monitor: pops expected read values as reads appear
    always @(negedge clk) begin
        if (rd_stb && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            total++;
            if (bus_rdata !== it.exp) begin
                bad++;
                $display("FAIL %s: got %h expected %h", it.tag, bus_rdata, it.exp);
            end
        end
    end

    // monitor: tag strobe sequence
    always @(negedge clk) begin
        if (!rst && tag_clr_vld) begin
            total++;
            if (tag_clr_idx !== IDX_W'(strobes % LINES)) begin
                bad++;
                $display("FAIL R5: index %0d expected %0d", tag_clr_idx, strobes % LINES);
            end
            strobes++;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a[ADDR_W-1:0]; bus_wr = 1'b1; bus_wdata = d; rd_stb = 1'b0;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        bus_addr = a[ADDR_W-1:0]; bus_wr = 1'b0;
        it.exp = e; it.tag = tag;
        q.push_back(it);
        rd_stb = 1'b1;
        @(negedge clk); #1;
        rd_stb = 1'b0;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] e, input string tag);
        total++;
        if (act !== e) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, act, e);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset values
        rd(8'h00, 32'h4, "R1 ctrl reset");
        rd(8'h04, 32'h0, "R1 status reset");
        rd(8'h08, 32'h0, "R1 ien reset");
        rd(8'h10, 32'h0, "R1 hits reset");
        rd(8'h14, 32'h0, "R1 miss reset");
        rd(8'h0C, 32'h0, "R1 fclr reads 0");
        rd(8'h18, 32'h0, "R1 unmapped");
        chk(irq, 0, "R9 irq reset");

        // R2/R4 enable and way lock
        wr(8'h00, 32'h1);
        rd(8'h00, 32'h1, "R2 enable, way written while disabled");
        wr(8'h00, 32'h5);
        rd(8'h00, 32'h1, "R4 way held while enabled");
        wr(8'h00, 32'h4);
        rd(8'h00, 32'h0, "R4 way held on disabling write");
        wr(8'h00, 32'h4);
        rd(8'h00, 32'h4, "R4 way written after disable");
        chk(strobes, 0, "R3 no walk without request bit");

        // R3/R5/R6 invalidation
        wr(8'h00, 32'h6);
        rd(8'h00, 32'h6, "R3 request bit visible");
        rd(8'h04, 32'h1, "R5 busy during walk");
        rd(8'h00, 32'h4, "R3 request bit cleared after busy");
        wr(8'h00, 32'h6);                        // dropped: walk still running
        repeat (10) @(posedge clk);
        rd(8'h04, 32'h2, "R6 done set, busy low");
        chk(strobes, LINES, "R5 strobe count");
        rd(8'h00, 32'h4, "R3 request while busy dropped");
        chk(strobes, LINES, "R3 no second walk");

        // R9/R8 done interrupt
        chk(irq, 0, "R9 irq masked");
        wr(8'h08, 32'h2);
        #1 chk(irq, 1, "R9 irq on done");
        wr(8'h04, 32'h7);
        rd(8'h04, 32'h2, "R8 status write ignored");
        wr(8'h0C, 32'h2);
        rd(8'h04, 32'h0, "R8 done cleared");
        chk(irq, 0, "R9 irq after clear");

        // R7 error
        @(posedge clk); #1 err_pulse = 1'b1;
        @(posedge clk); #1 err_pulse = 1'b0;
        rd(8'h04, 32'h4, "R7 error flag set");
        chk(irq, 0, "R9 error masked");
        wr(8'h08, 32'h4);
        #1 chk(irq, 1, "R9 irq on error");
        wr(8'h0C, 32'h4);
        rd(8'h04, 32'h0, "R8 error cleared");
        chk(irq, 0, "R9 irq low");

        // R10 counters
        wr(8'h00, 32'h0001_0004);
        @(posedge clk); #1 hit_pulse = 1'b1; miss_pulse = 1'b1;
        repeat (5) @(posedge clk);
        #1 hit_pulse = 1'b0; miss_pulse = 1'b0;
        rd(8'h10, 32'd5, "R10 hits counted");
        rd(8'h14, 32'd0, "R10 miss disabled");
        wr(8'h00, 32'h0003_0004);
        @(posedge clk); #1 miss_pulse = 1'b1;
        repeat (3) @(posedge clk);
        #1 miss_pulse = 1'b0;
        rd(8'h14, 32'd3, "R10 miss counted");

        // R11 clear beats increment
        @(posedge clk); #1;
        bus_addr = '0; bus_wr = 1'b1; bus_wdata = 32'h0007_0004;
        hit_pulse = 1'b1; miss_pulse = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0; hit_pulse = 1'b0; miss_pulse = 1'b0;
        rd(8'h10, 32'd0, "R11 hit clear wins");
        rd(8'h14, 32'd4, "R11 miss untouched");
        rd(8'h00, 32'h0003_0004, "R2 clear bits read 0");

        // R12 saturation
        @(posedge clk); #1 miss_pulse = 1'b1;
        repeat (65540) @(posedge clk);
        #1 miss_pulse = 1'b0;
        rd(8'h14, 32'h0000_FFFF, "R12 miss saturates");
        wr(8'h00, 32'h0008_0004);
        rd(8'h14, 32'd0, "R11 miss clear");

        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule